// File: doc/BRIEF.md
# Advance-Gated PWM Generator

A pulse-width modulator whose period counter moves forward only on clock cycles where an advance strobe is high. The strobe is usually a prescaler tick, so one fast clock can drive slow PWM rates without a second clock domain. With the strobe held low, the block is frozen: the counter and the output keep their values.

The period is 2^W-1 advance steps, not 2^W. Because of this, a duty word of zero gives a constant low output and a duty word of all ones gives a constant high output. No extra code or clamp is needed for either end. The duty word is taken at the first step of each period, so a change partway through a period cannot cut a pulse short. The output is a single registered bit. The reset is asynchronous and active low.

Top module: `pwm_adv_gen`

## Requirements
- R1: While rst_ni is low, pwm_o is low. Reset acts without waiting for a clock edge, and the period counter restarts at step 0.
- R2: On a clock edge where adv_i is low, neither the period counter nor pwm_o changes.
- R3: Over advance steps, the period counter runs 0, 1, ..., 2^W-2 and then returns to 0, so a period lasts 2^W-1 advance steps.
- R4: On each advance step, pwm_o is loaded with 1 when the current counter value is below the duty value in force for the period, and with 0 otherwise.
- R5: The duty in force for a period is the unsigned value of duty_i on the period's first advance step (counter 0). Changes to duty_i at other steps have no effect until the next period starts.
- R6: A duty of all ones keeps pwm_o high on every advance step. A duty of zero keeps pwm_o low on every advance step.
- R7: After reset is released with adv_i held low, pwm_o stays low, even when duty_i is all ones.
- R8: With W=2 and adv_i held high, duty codes 3, 2, 1 and 0 give an on-time of about 100%, 67%, 33% and 0%, measured over a 100-cycle window, within ±5 percentage points.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adv_i | input | 1 | Advance strobe; the counter steps on cycles where it is high |
| duty_i | input | W | Unsigned duty word |
| pwm_o | output | 1 | Registered PWM output |

## Verification
The hardest case to reach from the ports is a duty change partway through a period, because the counter phase cannot be seen. The bench resets the block so that the phase is known, and then counts its own advance steps. It loads an all-ones duty on step 0 and switches to zero at step 1. It then checks that the output stays high for the rest of that period and falls on the next step 0. The freeze case also needs care: the strobe is dropped while the output is high and again while it is low, so a hold of either value is checked.

// File: rtl/pwm_adv_pkg.sv
package pwm_adv_pkg;
  localparam int unsigned PWM_W_MIN = 2;
  localparam int unsigned PWM_W_MAX = 32;

  function automatic bit width_ok(int unsigned w);
    return (w >= PWM_W_MIN) && (w <= PWM_W_MAX);
  endfunction
endpackage

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  output logic [W-1:0] cnt_o,
  output logic         first_o
);
  // last step is 2^W-2, so all-ones duty stays above every count
  localparam logic [W-1:0] LAST = {{(W-1){1'b1}}, 1'b0};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (adv_i) begin
      if (cnt_q == LAST) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o   = cnt_q;
  assign first_o = (cnt_q == '0);
endmodule

// File: rtl/pwm_duty_latch.sv
module pwm_duty_latch #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         first_i,
  input  logic [W-1:0] duty_i,
  output logic [W-1:0] duty_eff_o,
  output logic [W-1:0] duty_q_o
);
  logic [W-1:0] duty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     duty_q <= '0;
    else if (load_i) duty_q <= duty_i;
  end

  // step 0 uses the incoming word directly so the new period starts on it
  assign duty_eff_o = first_i ? duty_i : duty_q;
  assign duty_q_o   = duty_q;
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] duty_i,
  output logic         pwm_o
);
  logic pwm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pwm_q <= 1'b0;
    else if (adv_i) pwm_q <= (cnt_i < duty_i);
  end

  assign pwm_o = pwm_q;
endmodule

// File: rtl/pwm_adv_gen.sv
module pwm_adv_gen
  import pwm_adv_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  input  logic [W-1:0] duty_i,
  output logic         pwm_o
);
  logic [W-1:0] cnt;
  logic         first;
  logic [W-1:0] duty_eff;
  logic [W-1:0] duty_q;

  generate
    if (!width_ok(W)) begin : g_bad_w
      $error("pwm_adv_gen: W out of range");
    end
  endgenerate

  pwm_period_ctr #(.W(W)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .adv_i   (adv_i),
    .cnt_o   (cnt),
    .first_o (first)
  );

  pwm_duty_latch #(.W(W)) u_duty (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (adv_i & first),
    .first_i    (first),
    .duty_i     (duty_i),
    .duty_eff_o (duty_eff),
    .duty_q_o   (duty_q)
  );

  pwm_out_stage #(.W(W)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (adv_i),
    .cnt_i  (cnt),
    .duty_i (duty_eff),
    .pwm_o  (pwm_o)
  );
endmodule

// File: rtl/pwm_adv_gen_chk.sv
module pwm_adv_gen_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         adv_i,
  input logic [W-1:0] duty_i,
  input logic         pwm_o,
  input logic [W-1:0] cnt_i,
  input logic [W-1:0] duty_q_i
);
  localparam logic [W-1:0] LAST = {{(W-1){1'b1}}, 1'b0};
  localparam logic [W-1:0] ONES = '1;

  a_r1_reset_low: assert property (@(posedge clk_i) !rst_ni |-> !pwm_o);

  a_r2_pwm_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(pwm_o));

  a_r2_cnt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(cnt_i));

  a_r3_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= LAST);

  a_r3_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && cnt_i == LAST) |=> (cnt_i == '0));

  a_r5_duty_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i != '0) |=> $stable(duty_q_i));

  a_r6_full_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && cnt_i == '0 && duty_i == ONES) |=> pwm_o);

  a_r6_zero_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && cnt_i == '0 && duty_i == '0) |=> !pwm_o);
endmodule

bind pwm_adv_gen pwm_adv_gen_chk #(.W(W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .adv_i    (adv_i),
  .duty_i   (duty_i),
  .pwm_o    (pwm_o),
  .cnt_i    (cnt),
  .duty_q_i (duty_q)
);

// File: tb/pwm_adv_gen_bench.sv
module pwm_adv_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 2;
  localparam int PER = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         adv = 1'b0;
  logic [W-1:0] duty = '0;
  logic         pwm;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_adv_gen #(.W(W)) u_pwm_adv_gen (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .adv_i  (adv),
    .duty_i (duty),
    .pwm_o  (pwm)
  );

  // behavioural reference
  int m_step = 0;
  int m_duty = 0;
  bit m_pwm  = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_step = 0; m_duty = 0; m_pwm = 1'b0;
    end else if (adv) begin
      if (m_step == 0) m_duty = int'(duty);
      m_pwm  = (m_step < m_duty);
      m_step = (m_step + 1) % PER;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) check(pwm == m_pwm, "R4 R5 model compare", int'(pwm), int'(m_pwm));
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic measure(output int hi);
    hi = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (pwm) hi++;
    end
    @(posedge clk);
    #2;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    check(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int hi;
    int last_rise;
    int exp_pct [4];
    bit prev;
    exp_pct[0] = 0; exp_pct[1] = 33; exp_pct[2] = 67; exp_pct[3] = 100;

    // R1: held in reset, strobe running
    duty = 2'b11; adv = 1'b1;
    tick(4);
    check(pwm == 1'b0, "R1 reset state", int'(pwm), 0);

    // R7: release frozen with all-ones duty
    adv = 1'b0;
    rst_n = 1'b1;
    measure(hi);
    check(hi == 0, "R7 frozen after reset", hi, 0);

    // R8/R6: duty sweep with strobe high
    adv = 1'b1;
    for (int d = 3; d >= 0; d--) begin
      duty = W'(d);
      tick(10);
      measure(hi);
      check((hi >= exp_pct[d] - 5) && (hi <= exp_pct[d] + 5), "R8 on percent", hi, exp_pct[d]);
      if (d == 3) check(hi == 100, "R6 all ones high", hi, 100);
      if (d == 0) check(hi == 0, "R6 zero low", hi, 0);
    end

    // R3: rising-edge spacing equals 2^W-1 steps
    duty = 2'b01;
    tick(10);
    last_rise = -1;
    prev = pwm;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (pwm && !prev) begin
        if (last_rise >= 0) check(c - last_rise == PER, "R3 period length", c - last_rise, PER);
        last_rise = c;
      end
      prev = pwm;
    end
    tick(1);

    // R2: freeze while high and while low
    duty = 2'b10;
    tick(6);
    while (pwm != 1'b1) tick(1);
    adv = 1'b0;
    tick(7);
    check(pwm == 1'b1, "R2 hold high", int'(pwm), 1);
    adv = 1'b1;
    while (pwm != 1'b0) tick(1);
    adv = 1'b0;
    tick(7);
    check(pwm == 1'b0, "R2 hold low", int'(pwm), 0);

    // R5: mid-period change from known phase
    rst_n = 1'b0;
    tick(1);
    rst_n = 1'b1;
    duty = 2'b11; adv = 1'b1;
    tick(1);
    check(pwm == 1'b1, "R4 step0 high", int'(pwm), 1);
    duty = 2'b00;
    tick(1);
    check(pwm == 1'b1, "R5 step1 keeps old duty", int'(pwm), 1);
    tick(1);
    check(pwm == 1'b1, "R5 step2 keeps old duty", int'(pwm), 1);
    tick(1);
    check(pwm == 1'b0, "R5 new duty at period start", int'(pwm), 0);

    // R1: asynchronous reset while high
    duty = 2'b11;
    tick(4);
    check(pwm == 1'b1, "R6 high before reset", int'(pwm), 1);
    @(posedge clk);
    #2;
    rst_n = 1'b0;
    #1;
    check(pwm == 1'b0, "R1 async reset", int'(pwm), 0);
    tick(2);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule